// File: doc/BRIEF.md
# Privileged Monitor-Segment Control Register

This block holds one 64-bit control word for a privileged monitor. The word carries the page-aligned physical base of a monitor segment and a valid bit that allows the monitor to be switched on. Software reaches the word through a simple register-access port with read and write strobes and write data. Side inputs describe the processor's state: whether it is in the privileged management mode, whether the feature exists on this part, and whether the access belongs to a VM-exit or VM-entry transition, together with whether that transition ends or begins in the privileged mode.

For every access the unit decides on one of three outcomes. The access completes, it raises a general-protection fault, or, for writes made in a transition that does not touch the privileged mode, it is dropped with no fault. The result appears one cycle after the request as a one-cycle `ack` or `fault` pulse. A fault always carries error code zero. The stored base is always driven as a 4 KiB-aligned physical address. The monitor-enable output is gated by the valid bit.

Top module: `mon_ctl_reg`

## Requirements
- R1: After reset the stored word is zero: `base_addr` is 0, `mon_en` is 0, and `ack`, `fault` and `rd_data` are 0.
- R2: A write made with `feat_sup`=1, outside a transition, with `priv_mode`=1, and with only bits 31:12 and 2:0 set, is stored. One cycle later `ack` is 1. From the next cycle on, `base_addr` equals `wr_data[31:12]` shifted left by 12, with its low 12 bits zero.
- R3: A read with `feat_sup`=1 completes in any mode and in any transition context. One cycle later `ack` is 1 and `rd_data` holds the stored word: bit 0 is valid, bits 2:1 are control bits returned unchanged, bits 31:12 are the base, and all other bits read as 0.
- R4: When `feat_sup`=0, every read or write gives `fault`=1 one cycle later and leaves the stored word unchanged.
- R5: A write made outside a transition while `priv_mode`=0 gives `fault`=1 and leaves the stored word unchanged.
- R6: A permitted write with any of bits 63:32 or 11:3 set gives `fault`=1 and leaves the stored word unchanged.
- R7: A write with `xfer_exit` or `xfer_entry` high and `xfer_ok`=0 is dropped. There is no `ack`, no `fault`, and no change to the word. When `xfer_ok`=1, the write is judged as a privileged write whatever the value of `priv_mode`.
- R8: `mon_en` equals the stored valid bit (bit 0) ANDed with `mon_req`, so it is never 1 while the valid bit is 0.
- R9: A faulting access gives exactly one `fault` cycle, with `fault_code`=0, `ack`=0 and `rd_data`=0. Fault causes are ranked in this order: unsupported feature, then wrong mode, then reserved bits. Only one fault is reported per access.
- R10: When `wr_en` and `rd_en` are both high, the access is handled as a write alone, and `rd_data` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write data |
| priv_mode | input | 1 | Processor is in privileged management mode |
| feat_sup | input | 1 | Feature is supported on this part |
| xfer_exit | input | 1 | Access is part of a VM-exit transition |
| xfer_entry | input | 1 | Access is part of a VM-entry transition |
| xfer_ok | input | 1 | The transition ends (exit) or begins (entry) in privileged mode |
| mon_req | input | 1 | Request to run the monitor |
| ack | output | 1 | Access completed (one cycle after the request) |
| fault | output | 1 | General-protection fault pulse |
| fault_code | output | 16 | Fault error code, always 0 |
| rd_data | output | 64 | Read data |
| base_addr | output | 32 | Physical monitor-segment base address |
| mon_en | output | 1 | Monitor enable |

## Verification
Writes are tried under each mode pattern: privileged, unprivileged, exit and entry transitions with `xfer_ok` low and high, and feature absent. This separates a fault from a silent drop and from acceptance. Payloads with a single reserved bit set, in the high field and in the low field, show whether the reserved mask covers both. Reads in an unprivileged exit context, reads with the feature absent, and simultaneous read and write check the read path. Back-to-back faults followed by an idle cycle confirm the pulse shape. Toggling `mon_req` against a cleared valid bit confirms the enable gating.

// File: rtl/mon_ctl_pkg.sv
`timescale 1ns/1ps
package mon_ctl_pkg;
    localparam int REG_W      = 64;
    localparam int PAGE_SHIFT = 12;
    localparam int BASE_HI    = 31;
    localparam int BASE_W     = BASE_HI - PAGE_SHIFT + 1;
    localparam int CTL_W      = 3;
    localparam int PADDR_W    = BASE_HI + 1;
    localparam int ERR_W      = 16;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CTL_W-2:0]  ctl;
        logic              valid;
    } mon_reg_t;

    typedef enum logic [1:0] {ACC_IDLE, ACC_READ, ACC_WRITE, ACC_DROP} acc_res_t;
    typedef enum logic [1:0] {FLT_NONE, FLT_UNSUP, FLT_MODE, FLT_RSVD} flt_cause_t;

    function automatic logic [REG_W-1:0] legal_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++)
            m[i] = (i < CTL_W) || (i >= PAGE_SHIFT && i <= BASE_HI);
        return m;
    endfunction

    function automatic logic [REG_W-1:0] to_word(mon_reg_t r);
        logic [REG_W-1:0] w;
        w = '0;
        w[BASE_HI:PAGE_SHIFT] = r.base;
        w[CTL_W-1:1]          = r.ctl;
        w[0]                  = r.valid;
        return w;
    endfunction

    function automatic mon_reg_t from_word(logic [REG_W-1:0] w);
        mon_reg_t r;
        r.base  = w[BASE_HI:PAGE_SHIFT];
        r.ctl   = w[CTL_W-1:1];
        r.valid = w[0];
        return r;
    endfunction
endpackage

// File: rtl/mon_ctl_arbiter.sv
`timescale 1ns/1ps
module mon_ctl_arbiter
    import mon_ctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         rd_en,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         priv_mode,
    input  logic         feat_sup,
    input  logic         xfer_exit,
    input  logic         xfer_entry,
    input  logic         xfer_ok,
    output acc_res_t     res,
    output flt_cause_t   cause
);
    localparam logic [W-1:0] LEGAL = legal_mask();

    logic in_xfer;
    logic rsvd_hit;

    assign in_xfer  = xfer_exit | xfer_entry;
    assign rsvd_hit = |(wr_data & ~LEGAL);

    always_comb begin
        res   = ACC_IDLE;
        cause = FLT_NONE;
        if (rd_en || wr_en) begin
            if (!feat_sup) begin
                cause = FLT_UNSUP;
            end else if (wr_en) begin
                if (in_xfer && !xfer_ok)
                    res = ACC_DROP;
                else if (!in_xfer && !priv_mode)
                    cause = FLT_MODE;
                else if (rsvd_hit)
                    cause = FLT_RSVD;
                else
                    res = ACC_WRITE;
            end else begin
                res = ACC_READ;
            end
        end
    end
endmodule

// File: rtl/mon_ctl_store.sv
`timescale 1ns/1ps
module mon_ctl_store
    import mon_ctl_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst,
    input  acc_res_t     res,
    input  logic [W-1:0] wr_data,
    output mon_reg_t     cur
);
    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else if (res == ACC_WRITE)
            cur <= from_word(wr_data);
    end
endmodule

// File: rtl/mon_ctl_resp.sv
`timescale 1ns/1ps
module mon_ctl_resp
    import mon_ctl_pkg::*;
#(
    parameter int W  = REG_W,
    parameter int EW = ERR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  acc_res_t      res,
    input  flt_cause_t    cause,
    input  logic [W-1:0]  rd_word,
    output logic          ack,
    output logic          fault,
    output logic [EW-1:0] fault_code,
    output logic [W-1:0]  rd_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ack        <= 1'b0;
            fault      <= 1'b0;
            fault_code <= '0;
            rd_data    <= '0;
        end else begin
            ack        <= (res == ACC_READ) || (res == ACC_WRITE);
            fault      <= (cause != FLT_NONE);
            fault_code <= '0;
            rd_data    <= (res == ACC_READ) ? rd_word : '0;
        end
    end
endmodule

// File: rtl/mon_ctl_reg.sv
`timescale 1ns/1ps
module mon_ctl_reg
    import mon_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               priv_mode,
    input  logic               feat_sup,
    input  logic               xfer_exit,
    input  logic               xfer_entry,
    input  logic               xfer_ok,
    input  logic               mon_req,
    output logic               ack,
    output logic               fault,
    output logic [ERR_W-1:0]   fault_code,
    output logic [REG_W-1:0]   rd_data,
    output logic [PADDR_W-1:0] base_addr,
    output logic               mon_en
);
    acc_res_t   res;
    flt_cause_t cause;
    mon_reg_t   cur;

    mon_ctl_arbiter #(.W(REG_W)) u_arb (
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .priv_mode(priv_mode), .feat_sup(feat_sup),
        .xfer_exit(xfer_exit), .xfer_entry(xfer_entry), .xfer_ok(xfer_ok),
        .res(res), .cause(cause)
    );

    mon_ctl_store #(.W(REG_W)) u_store (
        .clk(clk), .rst(rst), .res(res), .wr_data(wr_data), .cur(cur)
    );

    mon_ctl_resp #(.W(REG_W), .EW(ERR_W)) u_resp (
        .clk(clk), .rst(rst), .res(res), .cause(cause),
        .rd_word(to_word(cur)),
        .ack(ack), .fault(fault), .fault_code(fault_code), .rd_data(rd_data)
    );

    assign base_addr = {cur.base, {PAGE_SHIFT{1'b0}}};
    assign mon_en    = cur.valid & mon_req;
endmodule

// File: rtl/mon_ctl_chk.sv
`timescale 1ns/1ps
module mon_ctl_chk
    import mon_ctl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               rd_en,
    input logic               wr_en,
    input logic [REG_W-1:0]   wr_data,
    input logic               priv_mode,
    input logic               feat_sup,
    input logic               xfer_exit,
    input logic               xfer_entry,
    input logic               xfer_ok,
    input logic               ack,
    input logic               fault,
    input logic [ERR_W-1:0]   fault_code,
    input logic [REG_W-1:0]   rd_data,
    input logic [PADDR_W-1:0] base_addr,
    input logic               mon_en,
    input logic               valid_q
);
    localparam logic [REG_W-1:0] LEGAL = legal_mask();

    // R2
    base_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        base_addr[PAGE_SHIFT-1:0] == '0);

    // R4
    unsup_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) && !feat_sup |=> fault && $stable(base_addr));

    // R5
    mode_fault_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && feat_sup && !xfer_exit && !xfer_entry && !priv_mode
        |=> fault && $stable(base_addr));

    // R6
    rsvd_fault_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && feat_sup && priv_mode && !xfer_exit && !xfer_entry
        && ((wr_data & ~LEGAL) != '0) |=> fault && $stable(base_addr));

    // R7
    xfer_drop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && feat_sup && (xfer_exit || xfer_entry) && !xfer_ok
        |=> !fault && !ack && $stable(base_addr));

    // R8
    en_gated_chk: assert property (@(posedge clk) disable iff (rst)
        mon_en |-> valid_q);

    // R9
    fault_shape_chk: assert property (@(posedge clk) disable iff (rst)
        fault |-> !ack && fault_code == '0 && rd_data == '0);

    // R9
    fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en && !wr_en |=> !fault && !ack);
endmodule

bind mon_ctl_reg mon_ctl_chk u_chk (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
    .priv_mode(priv_mode), .feat_sup(feat_sup), .xfer_exit(xfer_exit),
    .xfer_entry(xfer_entry), .xfer_ok(xfer_ok), .ack(ack), .fault(fault),
    .fault_code(fault_code), .rd_data(rd_data), .base_addr(base_addr),
    .mon_en(mon_en), .valid_q(cur.valid)
);

// File: tb/mon_ctl_reg_bench.sv
`timescale 1ns/1ps
module mon_ctl_reg_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 0, wr_en = 0, priv_mode = 0, feat_sup = 1;
    logic        xfer_exit = 0, xfer_entry = 0, xfer_ok = 0, mon_req = 0;
    logic [63:0] wr_data = '0;
    logic        ack, fault, mon_en;
    logic [15:0] fault_code;
    logic [63:0] rd_data;
    logic [31:0] base_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    mon_ctl_reg u_mon_ctl_reg (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .priv_mode(priv_mode), .feat_sup(feat_sup), .xfer_exit(xfer_exit),
        .xfer_entry(xfer_entry), .xfer_ok(xfer_ok), .mon_req(mon_req),
        .ack(ack), .fault(fault), .fault_code(fault_code), .rd_data(rd_data),
        .base_addr(base_addr), .mon_en(mon_en)
    );

    typedef struct {
        string       req;
        logic        ack;
        logic        fault;
        logic [63:0] rd;
        logic [31:0] base;
        logic        men;
    } exp_t;

    exp_t        sb[$];
    logic [63:0] m_word = '0;
    localparam logic [63:0] LEGAL = 64'h0000_0000_FFFF_F007;

    task automatic check(input string req, input bit ok, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic acc(input string req, input logic r, input logic w,
                       input logic [63:0] d, input logic pv, input logic fs,
                       input logic ex, input logic en, input logic ok,
                       input logic mr);
        exp_t e;
        logic tr;
        @(negedge clk);
        rd_en = r; wr_en = w; wr_data = d; priv_mode = pv; feat_sup = fs;
        xfer_exit = ex; xfer_entry = en; xfer_ok = ok; mon_req = mr;
        e.req = req; e.ack = 0; e.fault = 0; e.rd = '0;
        tr = ex | en;
        if (r || w) begin
            if (!fs) e.fault = 1;
            else if (w) begin
                if (tr && !ok) ;
                else if (!tr && !pv) e.fault = 1;
                else if ((d & ~LEGAL) != 0) e.fault = 1;
                else begin e.ack = 1; m_word = d; end
            end else begin
                e.ack = 1; e.rd = m_word;
            end
        end
        e.base = {m_word[31:12], 12'h000};
        e.men  = m_word[0] & mr;
        sb.push_back(e);
    endtask

    task automatic idle(input string req, input logic mr);
        acc(req, 0, 0, 64'h0, 0, 1, 0, 0, 0, mr);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.req, ack === e.ack, "ack", {63'h0, ack}, {63'h0, e.ack});
                check(e.req, fault === e.fault, "fault", {63'h0, fault}, {63'h0, e.fault});
                check(e.req, rd_data === e.rd, "rd_data", rd_data, e.rd);
                check(e.req, base_addr === e.base, "base_addr", {32'h0, base_addr}, {32'h0, e.base});
                check(e.req, mon_en === e.men, "mon_en", {63'h0, mon_en}, {63'h0, e.men});
                check(e.req, fault_code === 16'h0, "fault_code", {48'h0, fault_code}, 64'h0);
            end
        end
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", base_addr === 32'h0, "base_addr", {32'h0, base_addr}, 64'h0);
        check("R1", mon_en === 1'b0 && ack === 1'b0 && fault === 1'b0, "ctl outs",
              {61'h0, mon_en, ack, fault}, 64'h0);
        check("R1", rd_data === 64'h0, "rd_data", rd_data, 64'h0);
        acc("R1", 1, 0, 64'h0, 0, 1, 0, 0, 0, 1);

        // R2 accepted write, R8 enable follows valid and request
        acc("R2", 0, 1, 64'h0000_0000_1234_5007, 1, 1, 0, 0, 0, 1);
        idle("R8", 1);
        idle("R8", 0);
        // R3 read back and in unprivileged exit/entry contexts
        acc("R3", 1, 0, 64'h0, 1, 1, 0, 0, 0, 1);
        acc("R3", 1, 0, 64'h0, 0, 1, 1, 0, 0, 1);
        acc("R3", 1, 0, 64'h0, 0, 1, 0, 1, 0, 1);
        acc("R3", 1, 0, 64'h0, 0, 1, 0, 0, 0, 1);

        // R5 unprivileged write faults, then R9 pulse ends
        acc("R5", 0, 1, 64'h0000_0000_ABCD_E001, 0, 1, 0, 0, 0, 1);
        idle("R9", 1);
        // R6 reserved bits, high and low field, back to back
        acc("R6", 0, 1, 64'h0000_0100_0000_1001, 1, 1, 0, 0, 0, 1);
        acc("R6", 0, 1, 64'h0000_0000_0000_2009, 1, 1, 0, 0, 0, 1);
        acc("R6", 0, 1, 64'h8000_0000_0000_0001, 1, 1, 0, 0, 0, 1);
        idle("R9", 1);

        // R7 silent drops in both transition kinds
        acc("R7", 0, 1, 64'h0000_0000_5555_5001, 1, 1, 1, 0, 0, 1);
        acc("R7", 0, 1, 64'h0000_0000_6666_6001, 0, 1, 0, 1, 0, 1);
        acc("R7", 1, 0, 64'h0, 0, 1, 0, 0, 0, 1);
        // R7 transition with xfer_ok accepted without priv_mode
        acc("R7", 0, 1, 64'h0000_0000_7777_7003, 0, 1, 1, 0, 1, 1);
        acc("R7", 1, 0, 64'h0, 0, 1, 0, 0, 0, 1);
        // R7 transition with xfer_ok still checks reserved bits
        acc("R7", 0, 1, 64'h0000_0000_0000_0010, 0, 1, 0, 1, 1, 1);

        // R4 feature absent: read and write fault, also over other faults (R9)
        acc("R4", 1, 0, 64'h0, 1, 0, 0, 0, 0, 1);
        acc("R4", 0, 1, 64'h0000_0000_8888_8001, 1, 0, 0, 0, 0, 1);
        acc("R9", 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0, 1);
        acc("R4", 1, 0, 64'h0, 1, 1, 0, 0, 0, 1);

        // R8 clear valid: no enable even with request
        acc("R8", 0, 1, 64'h0000_0000_9999_9006, 1, 1, 0, 0, 0, 1);
        idle("R8", 1);
        acc("R3", 1, 0, 64'h0, 1, 1, 0, 0, 0, 1);

        // R10 simultaneous read and write
        acc("R10", 1, 1, 64'h0000_0000_FFFF_F001, 1, 1, 0, 0, 0, 1);
        acc("R10", 1, 0, 64'h0, 1, 1, 0, 0, 0, 1);
        idle("R10", 0);

        @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule